// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This block sits beside a processor core and decides when a pending interrupt is taken. It watches a 3-bit encoded request level and a 3-bit priority mask. Once it accepts an interrupt it runs a short acknowledge handshake with the bus. The handshake presents the accepted level on the address lines, flagged as an interrupt-acknowledge access. It then waits for exactly one kind of reply: a vector number supplied by the device, a request for an automatically generated vector, or a bus error. From that reply it produces the final 8-bit exception vector number and a one-cycle "taken" strobe.

Levels 1 to 6 are maskable and are compared against the mask. Level 7 is non-maskable and reacts to transitions rather than to the level, so a request held at 7 is serviced once. It is serviced again only when the mask is lowered from 7 while the request still sits at 7. The mask register is loaded with the accepted level on acceptance, and software can write it through a one-cycle write port.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A request level from 1 to 6 starts an acknowledge only when it is strictly greater than the current mask. A level at or below the mask leaves `ack_cycle` low and the mask unchanged.
- R2: On acceptance the mask takes the accepted level. This has priority over a mask write in the same cycle.
- R3: One clock edge after acceptance, `ack_cycle` is high and `ack_addr` carries the accepted level. Both stay there until the response is taken, and `ack_addr` reads 0 whenever `ack_cycle` is low.
- R4: An autovector reply (`resp_autovec` alone) yields vector 24 plus the level, which gives 25 to 31.
- R5: A bus-error reply (`resp_berr` alone) marks the interrupt spurious and yields vector 24.
- R6: A device vector reply (`resp_vec_valid` alone) passes `resp_vec` unchanged. This includes the uninitialized value 15.
- R7: A change of the request level to 7 from any other value starts a level-7 acknowledge whatever the mask holds. A change seen while a handshake is busy is held and serviced afterwards.
- R8: A mask change from 7 to a lower value while the request stays at 7 starts another level-7 acknowledge.
- R9: A request held at 7 with no such mask change does not start a second acknowledge.
- R10: Request level 0 never starts an acknowledge.
- R11: The handshake waits until exactly one of the three reply inputs is high. No reply, or two or more replies together, keeps it waiting. The taken strobe `irq_taken` is high for exactly one cycle, together with the new `vec_num`.
- R12: After reset the mask is 7, and `ack_cycle`, `ack_addr`, `irq_taken` and `vec_num` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_level | input | 3 | Encoded interrupt request level, 0 means none |
| mask_wr | input | 1 | Write strobe for the priority mask |
| mask_wdata | input | 3 | New priority mask value |
| resp_vec_valid | input | 1 | Device supplies a vector on `resp_vec` |
| resp_vec | input | 8 | Vector number from the device |
| resp_autovec | input | 1 | Device requests an automatic vector |
| resp_berr | input | 1 | Acknowledge access ended in a bus error |
| ack_cycle | output | 1 | Interrupt-acknowledge access in progress |
| ack_addr | output | 3 | Level being acknowledged, on the address lines |
| irq_taken | output | 1 | One-cycle strobe: interrupt taken, `vec_num` valid |
| vec_num | output | 8 | Final exception vector number, held until the next one |
| prio_mask | output | 3 | Current priority mask |

## Verification
A request presented before a clock edge shows up on `ack_cycle`, `ack_addr` and `prio_mask` right after that edge. A mask drop from 7 needs one more edge, because the old mask is compared through a register. The handshake enters its waiting state one edge after acceptance. A reply driven there is taken at the following edge, and `irq_taken` and `vec_num` change at that edge, then the strobe falls one edge later. The bench drives every input just after a falling edge and samples at the next falling edge, which puts each check exactly in the cycle where the result is due. Refusals are checked over several further cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } ack_state_e;

  // true when exactly one of the three reply kinds is present
  function automatic logic single_reply(input logic v, input logic a, input logic b);
    logic [2:0] r;
    r = {v, a, b};
    return (r == 3'b100) || (r == 3'b010) || (r == 3'b001);
  endfunction

endpackage

// File: rtl/irq_level_watch.sv
module irq_level_watch #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req_level,
  input  logic [LVL_W-1:0] mask,
  input  logic             idle,
  output logic             accept,
  output logic [LVL_W-1:0] accept_lvl
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic [LVL_W-1:0] prev_req;
  logic [LVL_W-1:0] prev_mask;
  logic             nmi_pend;
  logic             nmi_edge;
  logic             nmi_unmask;
  logic             nmi_now;
  logic             maskable;

  // level 7: transition into 7, or mask lowered from 7 while request sits at 7
  assign nmi_edge   = (req_level == TOP_LVL) && (prev_req != TOP_LVL);
  assign nmi_unmask = (req_level == TOP_LVL) && (prev_mask == TOP_LVL) && (mask != TOP_LVL);
  assign nmi_now    = nmi_pend || nmi_edge || nmi_unmask;

  assign maskable = (req_level != '0) && (req_level != TOP_LVL) && (req_level > mask);

  assign accept     = idle && (nmi_now || maskable);
  assign accept_lvl = nmi_now ? TOP_LVL : req_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_req  <= '0;
      prev_mask <= TOP_LVL;
      nmi_pend  <= 1'b0;
    end else begin
      prev_req  <= req_level;
      prev_mask <= mask;
      // an event seen while busy is kept until the handshake is free
      nmi_pend  <= nmi_now && !idle;
    end
  end

endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int AUTOVEC_BASE = 24,
  parameter int SPURIOUS_VEC = 24
) (
  input  logic [LVL_W-1:0] level,
  input  logic             resp_vec_valid,
  input  logic [VEC_W-1:0] resp_vec,
  input  logic             resp_autovec,
  input  logic             resp_berr,
  output logic             reply_ok,
  output logic [VEC_W-1:0] vector
);
  import irq_pkg::*;

  localparam logic [VEC_W-1:0] AUTO_BASE_V = VEC_W'(AUTOVEC_BASE);
  localparam logic [VEC_W-1:0] SPUR_V      = VEC_W'(SPURIOUS_VEC);

  logic [VEC_W-1:0] level_ext;

  generate
    if (VEC_W > LVL_W) begin : g_pad
      assign level_ext = {{(VEC_W-LVL_W){1'b0}}, level};
    end else begin : g_trim
      assign level_ext = level[VEC_W-1:0];
    end
  endgenerate

  assign reply_ok = single_reply(resp_vec_valid, resp_autovec, resp_berr);

  always_comb begin
    if (resp_berr)         vector = SPUR_V;
    else if (resp_autovec) vector = AUTO_BASE_V + level_ext;
    else if (resp_vec_valid) vector = resp_vec;
    else                   vector = '0;
  end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm #(
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int AUTOVEC_BASE = 24,
  parameter int SPURIOUS_VEC = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [LVL_W-1:0]  accept_lvl,
  input  logic              resp_vec_valid,
  input  logic [VEC_W-1:0]  resp_vec,
  input  logic              resp_autovec,
  input  logic              resp_berr,
  output irq_pkg::ack_state_e state,
  output logic              idle,
  output logic              ack_cycle,
  output logic [LVL_W-1:0]  ack_addr,
  output logic              irq_taken,
  output logic [VEC_W-1:0]  vec_num
);
  import irq_pkg::*;

  logic [LVL_W-1:0] cur_lvl;
  logic             reply_ok;
  logic [VEC_W-1:0] sel_vec;

  irq_vector_sel #(
    .LVL_W(LVL_W), .VEC_W(VEC_W),
    .AUTOVEC_BASE(AUTOVEC_BASE), .SPURIOUS_VEC(SPURIOUS_VEC)
  ) u_vsel (
    .level          (cur_lvl),
    .resp_vec_valid (resp_vec_valid),
    .resp_vec       (resp_vec),
    .resp_autovec   (resp_autovec),
    .resp_berr      (resp_berr),
    .reply_ok       (reply_ok),
    .vector         (sel_vec)
  );

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_lvl   <= '0;
      ack_cycle <= 1'b0;
      ack_addr  <= '0;
      irq_taken <= 1'b0;
      vec_num   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          irq_taken <= 1'b0;
          if (accept) begin
            state     <= ST_ACK;
            cur_lvl   <= accept_lvl;
            ack_cycle <= 1'b1;
            ack_addr  <= accept_lvl;
          end
        end
        ST_ACK: begin
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (reply_ok) begin
            state     <= ST_DONE;
            ack_cycle <= 1'b0;
            ack_addr  <= '0;
            irq_taken <= 1'b1;
            vec_num   <= sel_vec;
          end
        end
        ST_DONE: begin
          irq_taken <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int AUTOVEC_BASE = 24,
  parameter int SPURIOUS_VEC = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req_level,
  input  logic             mask_wr,
  input  logic [LVL_W-1:0] mask_wdata,
  input  logic             resp_vec_valid,
  input  logic [VEC_W-1:0] resp_vec,
  input  logic             resp_autovec,
  input  logic             resp_berr,
  output logic             ack_cycle,
  output logic [LVL_W-1:0] ack_addr,
  output logic             irq_taken,
  output logic [VEC_W-1:0] vec_num,
  output logic [LVL_W-1:0] prio_mask
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  irq_pkg::ack_state_e state_q;
  logic                idle;
  logic                accept;
  logic [LVL_W-1:0]    accept_lvl;
  logic [LVL_W-1:0]    mask_q;

  irq_level_watch #(.LVL_W(LVL_W)) u_watch (
    .clk        (clk),
    .rst        (rst),
    .req_level  (req_level),
    .mask       (mask_q),
    .idle       (idle),
    .accept     (accept),
    .accept_lvl (accept_lvl)
  );

  irq_ack_fsm #(
    .LVL_W(LVL_W), .VEC_W(VEC_W),
    .AUTOVEC_BASE(AUTOVEC_BASE), .SPURIOUS_VEC(SPURIOUS_VEC)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .accept         (accept),
    .accept_lvl     (accept_lvl),
    .resp_vec_valid (resp_vec_valid),
    .resp_vec       (resp_vec),
    .resp_autovec   (resp_autovec),
    .resp_berr      (resp_berr),
    .state          (state_q),
    .idle           (idle),
    .ack_cycle      (ack_cycle),
    .ack_addr       (ack_addr),
    .irq_taken      (irq_taken),
    .vec_num        (vec_num)
  );

  // acceptance outranks a software write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= TOP_LVL;
    else if (accept)  mask_q <= accept_lvl;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign prio_mask = mask_q;

endmodule

// File: rtl/irq_ack_checks.sv
module irq_ack_checks #(
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int AUTOVEC_BASE = 24,
  parameter int SPURIOUS_VEC = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [LVL_W-1:0]    req_level,
  input logic                resp_vec_valid,
  input logic [VEC_W-1:0]    resp_vec,
  input logic                resp_autovec,
  input logic                resp_berr,
  input logic                ack_cycle,
  input logic [LVL_W-1:0]    ack_addr,
  input logic                irq_taken,
  input logic [VEC_W-1:0]    vec_num,
  input logic [LVL_W-1:0]    prio_mask,
  input irq_pkg::ack_state_e state
);
  import irq_pkg::*;
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  assert_mask_gate_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_cycle) |-> (ack_addr == TOP_LVL) || (ack_addr > $past(prio_mask)));

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_cycle) |-> prio_mask == ack_addr);

  assert_ack_level_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_cycle) && ack_addr != TOP_LVL) |-> ack_addr == $past(req_level));

  assert_no_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ack_cycle |-> ack_addr != '0);

  assert_autovec_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_taken) && $past(resp_autovec && !resp_berr && !resp_vec_valid))
      |-> vec_num == VEC_W'(AUTOVEC_BASE) + VEC_W'($past(ack_addr)));

  assert_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_taken) && $past(resp_berr && !resp_autovec && !resp_vec_valid))
      |-> vec_num == VEC_W'(SPURIOUS_VEC));

  assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_taken) && $past(resp_vec_valid && !resp_autovec && !resp_berr))
      |-> vec_num == $past(resp_vec));

  assert_hold_wait_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && $countones({resp_vec_valid, resp_autovec, resp_berr}) != 1)
      |=> state == ST_WAIT);

  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    irq_taken |=> !irq_taken);

  assert_strobe_after_wait_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_taken) |-> $past(state) == ST_WAIT);

endmodule

bind irq_ack_ctrl irq_ack_checks #(
  .LVL_W(LVL_W), .VEC_W(VEC_W),
  .AUTOVEC_BASE(AUTOVEC_BASE), .SPURIOUS_VEC(SPURIOUS_VEC)
) u_checks (
  .clk            (clk),
  .rst            (rst),
  .req_level      (req_level),
  .resp_vec_valid (resp_vec_valid),
  .resp_vec       (resp_vec),
  .resp_autovec   (resp_autovec),
  .resp_berr      (resp_berr),
  .ack_cycle      (ack_cycle),
  .ack_addr       (ack_addr),
  .irq_taken      (irq_taken),
  .vec_num        (vec_num),
  .prio_mask      (prio_mask),
  .state          (state_q)
);

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req_level = '0;
  logic       mask_wr = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic       resp_vec_valid = 1'b0;
  logic [7:0] resp_vec = '0;
  logic       resp_autovec = 1'b0;
  logic       resp_berr = 1'b0;
  logic       ack_cycle;
  logic [2:0] ack_addr;
  logic       irq_taken;
  logic [7:0] vec_num;
  logic [2:0] prio_mask;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ack_ctrl i_irq_ack_ctrl (
    .clk(clk), .rst(rst), .req_level(req_level),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .resp_vec_valid(resp_vec_valid), .resp_vec(resp_vec),
    .resp_autovec(resp_autovec), .resp_berr(resp_berr),
    .ack_cycle(ack_cycle), .ack_addr(ack_addr), .irq_taken(irq_taken),
    .vec_num(vec_num), .prio_mask(prio_mask)
  );

  // kind: 0 none, 1 device vector, 2 autovector, 3 bus error
  typedef struct packed {
    logic [2:0] mask;
    logic [2:0] lvl;
    logic [1:0] kind;
    logic [7:0] vec;
    logic       take;
    logic [7:0] expv;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 3'd3, 2'd2, 8'h00, 1'b1, 8'd27},
    '{3'd2, 3'd5, 2'd1, 8'h40, 1'b1, 8'h40},
    '{3'd4, 3'd6, 2'd3, 8'h00, 1'b1, 8'd24},
    '{3'd4, 3'd4, 2'd0, 8'h00, 1'b0, 8'd0},
    '{3'd5, 3'd2, 2'd0, 8'h00, 1'b0, 8'd0},
    '{3'd0, 3'd1, 2'd1, 8'd15, 1'b1, 8'd15},
    '{3'd7, 3'd7, 2'd2, 8'h00, 1'b1, 8'd31},
    '{3'd3, 3'd0, 2'd0, 8'h00, 1'b0, 8'd0},
    '{3'd0, 3'd6, 2'd2, 8'h00, 1'b1, 8'd30}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  task automatic write_mask(input logic [2:0] m);
    @(negedge clk);
    mask_wr = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic drive_reply(input logic [1:0] kind, input logic [7:0] v);
    resp_vec_valid = (kind == 2'd1);
    resp_vec       = v;
    resp_autovec   = (kind == 2'd2);
    resp_berr      = (kind == 2'd3);
  endtask

  function automatic string kind_tag(input logic [1:0] kind);
    if (kind == 2'd1) return "R6";
    if (kind == 2'd2) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 mask", prio_mask, 7);
    chk("R12 ack_cycle", ack_cycle, 0);
    chk("R12 ack_addr", ack_addr, 0);
    chk("R12 irq_taken", irq_taken, 0);
    chk("R12 vec_num", vec_num, 0);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      write_mask(ROWS[i].mask);
      req_level = ROWS[i].lvl;
      @(negedge clk);
      chk(ROWS[i].lvl == 3'd7 ? "R7 start" :
          (ROWS[i].lvl == 3'd0 ? "R10 start" : "R1 start"),
          ack_cycle, ROWS[i].take);
      if (ROWS[i].take) begin
        chk("R3 ack_addr", ack_addr, ROWS[i].lvl);
        chk("R2 mask load", prio_mask, ROWS[i].lvl);
        req_level = '0;
        @(negedge clk);
        drive_reply(ROWS[i].kind, ROWS[i].vec);
        @(negedge clk);
        chk("R11 strobe", irq_taken, 1);
        chk(kind_tag(ROWS[i].kind), vec_num, ROWS[i].expv);
        drive_reply(2'd0, 8'h00);
        @(negedge clk);
        chk("R11 strobe width", irq_taken, 0);
      end else begin
        repeat (2) @(negedge clk);
        chk(ROWS[i].lvl == 3'd0 ? "R10 idle" : "R1 idle", ack_cycle, 0);
        chk("R1 mask kept", prio_mask, ROWS[i].mask);
        req_level = '0;
        @(negedge clk);
      end
    end

    // R9 then R8: held level 7, then mask lowered from 7
    write_mask(3'd0);
    req_level = 3'd7;
    @(negedge clk);
    chk("R7 edge", ack_cycle, 1);
    @(negedge clk);
    drive_reply(2'd2, 8'h00);
    @(negedge clk);
    chk("R4 level7 vector", vec_num, 31);
    drive_reply(2'd0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 no refire", ack_cycle, 0);
    end
    chk("R2 mask after nmi", prio_mask, 7);
    write_mask(3'd2);
    @(negedge clk);
    chk("R8 refire", ack_cycle, 1);
    chk("R8 ack_addr", ack_addr, 7);
    @(negedge clk);
    drive_reply(2'd3, 8'h00);
    @(negedge clk);
    chk("R5 spurious", vec_num, 24);
    drive_reply(2'd0, 8'h00);
    req_level = '0;
    repeat (2) @(negedge clk);

    // R11: wait with no reply, then two replies, then one
    write_mask(3'd0);
    req_level = 3'd4;
    @(negedge clk);
    chk("R1 accept", ack_cycle, 1);
    req_level = '0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 wait none", ack_cycle, 1);
      chk("R11 no strobe", irq_taken, 0);
    end
    resp_autovec = 1'b1; resp_berr = 1'b1;
    @(negedge clk);
    chk("R11 wait double", ack_cycle, 1);
    chk("R3 addr held", ack_addr, 4);
    resp_autovec = 1'b0;
    @(negedge clk);
    chk("R11 taken", irq_taken, 1);
    chk("R5 after hold", vec_num, 24);
    chk("R3 addr cleared", ack_addr, 0);
    resp_berr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule